// File: doc/BRIEF.md
# Polled Asynchronous Serial Receiver

This block receives characters from one idle-high asynchronous serial line and presents them to a processor core that polls for them. A single 32-bit configuration word sets both the bit period, in system clocks with a fractional part, and the number of data bits per character. Because the fraction is kept, the receiver can match baud rates that do not divide the system clock evenly.

A frame begins with a falling edge on the line. The receiver checks the start bit half a period later and drops the frame if the line has already returned high. It then samples each data bit and the stop bit at its centre. The sample instants come from a fixed-point target that adds one full period per bit, so rounding error does not build up across a long character. Data bits enter at the top of a shift register, so a character of n bits ends up left-justified in the 32-bit word. A character of eight bits is recovered by shifting right by 24.

The finished character goes into a one-entry buffer and raises a ready flag. A read strobe acknowledges the character and clears the flag. If another character completes before the read, it overwrites the buffer and sets a sticky overrun flag. A stop bit sampled low sets a framing-error flag, and the character is still delivered.

Top module: `serial_rx_poll`

## Requirements
- R1: After reset, rxReady, rxOverrun and rxFrameErr are low and rxWord is zero. The configuration word resets to RESET_CFG, which by default is 16 clocks per bit and 8 data bits.
- R2: The bit period in 1/65536 clock units is cfgWord[31:5] followed by five zero bits. cfgWord[31:16] is the integer number of clocks and must be at least 4. cfgWord[15:5] is the upper part of the fraction. The data-bit count is cfgWord[4:0]+1, so 7 selects 8 bits. A frame uses the values held when its start edge is detected.
- R3: A frame starts only on a high-to-low change of rxIn while the receiver is idle. If the start bit reads high at its mid-point, the frame is dropped and no flag or data changes.
- R4: Sample k is taken at Pfix/2 + k*Pfix from the start of the frame, computed in fixed point without cumulative rounding. Sample 0 is the start bit, samples 1..n are the data bits and sample n+1 is the stop bit. rxReady rises right after rising edge E0 + 3 + floor((Pfix/2 + (n+1)*Pfix) / 65536), where E0 is the first rising edge at which rxIn is low.
- R5: The first data bit received lands in bit 32-n of rxWord and the last in bit 31. All bits below 32-n are zero.
- R6: rxReady stays high from a delivery until a rising edge with rdStrobe high. That edge clears it unless a new delivery happens on the same edge.
- R7: A delivery while rxReady is high and rdStrobe is low overwrites rxWord and sets rxOverrun. rxOverrun stays high until an edge with rdStrobe high.
- R8: When a read and a delivery fall on the same edge, the new character is kept, rxReady stays high and rxOverrun ends low.
- R9: On each delivery, rxFrameErr takes the inverse of the sampled stop bit. A read with no delivery on the same edge clears it.
- R10: Data-bit counts of 5, 8 and 32 are all received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Writes cfgWord into the configuration register |
| cfgWord | input | 32 | Period (16.16 fixed point, low 5 bits reused) and data-bit count minus one |
| rdStrobe | input | 1 | Acknowledges the buffered character |
| rxIn | input | 1 | Serial line, idle high |
| rxWord | output | 32 | Last received character, left-justified |
| rxReady | output | 1 | A character is waiting |
| rxOverrun | output | 1 | Sticky: a character was overwritten before being read |
| rxFrameErr | output | 1 | The stop bit of the buffered character was low |

## Verification
A software read and a character delivery can land on the same clock edge. In that case the receiver must keep the new character and raise no overrun. The bench provokes this by computing the delivery edge in advance from the fixed-point period and asserting rdStrobe during the cycle just before it, while an earlier character is still unread. A reference model tracks the ready, overrun, framing and data state at every edge from the requirements alone and is compared on every clock. It covers this collision case as well as the plain overrun case, where no read comes.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} rxPhase_t;

  typedef struct packed {
    logic startFrame;
    logic nextSlot;
    logic shiftBit;
    logic deliver;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int CNTF_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fallSeen,
  input  logic              sampleHit,
  input  logic              rxBit,
  input  logic [CNTF_W-1:0] lastIdx,
  output rxStrobe_t         strobe
);
  rxPhase_t phaseQ;
  logic [CNTF_W-1:0] bitIdx;

  always_comb begin
    strobe = '0;
    unique case (phaseQ)
      PH_IDLE:  strobe.startFrame = fallSeen;
      PH_START: strobe.nextSlot   = sampleHit & ~rxBit;
      PH_DATA: begin
        strobe.shiftBit = sampleHit;
        strobe.nextSlot = sampleHit;
      end
      PH_STOP:  strobe.deliver    = sampleHit;
      default:  strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (phaseQ)
        PH_IDLE: if (strobe.startFrame) begin
          phaseQ <= PH_START;
          bitIdx <= '0;
        end
        PH_START: if (sampleHit) phaseQ <= rxBit ? PH_IDLE : PH_DATA;
        PH_DATA: if (sampleHit) begin
          if (bitIdx == lastIdx) phaseQ <= PH_STOP;
          else bitIdx <= bitIdx + 1'b1;
        end
        PH_STOP: if (sampleHit) phaseQ <= PH_IDLE;
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  // R3: a start bit read high at mid-point drops the frame
  p_glitch_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_START && sampleHit && rxBit) |=> (phaseQ == PH_IDLE));

  // R10: bit index never passes the configured count
  p_bit_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DATA) |-> (bitIdx <= lastIdx));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.shiftBit, strobe.deliver}));
endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int          WORD_W      = 32,
  parameter int          CNT_W       = 24,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] RESET_CFG   = 32'h0010_0007
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWord,
  input  logic              rdStrobe,
  input  logic              rxIn,
  input  rxStrobe_t         strobe,
  output logic              fallSeen,
  output logic              sampleHit,
  output logic              rxBit,
  output logic [$clog2(WORD_W)-1:0] lastIdx,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxReady,
  output logic              rxOverrun,
  output logic              rxFrameErr
);
  localparam int FRAC_W = 16;
  localparam int FIX_W  = CNT_W + FRAC_W;
  localparam int CNTF_W = $clog2(WORD_W);

  logic [31:0]            cfgQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevS;
  logic [31:0]            periodQ;
  logic [FIX_W-1:0]       targetQ;
  logic [CNT_W-1:0]       cntQ;
  logic [WORD_W-1:0]      shregQ;
  logic [CNTF_W-1:0]      lastQ;
  logic [31:0]            cfgPeriod;

  assign cfgPeriod = {cfgQ[31:5], 5'b0};
  assign rxBit     = syncQ[SYNC_STAGES-1];
  assign fallSeen  = prevS & ~rxBit;
  assign sampleHit = (cntQ == targetQ[FIX_W-1:FRAC_W]);
  assign lastIdx   = lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= RESET_CFG;
      syncQ <= '1;
      prevS <= 1'b1;
    end else begin
      if (cfgWrEn) cfgQ <= cfgWord;
      syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      prevS <= rxBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '0;
      targetQ <= '0;
      cntQ    <= '0;
      shregQ  <= '0;
      lastQ   <= '0;
    end else if (strobe.startFrame) begin
      periodQ <= cfgPeriod;
      targetQ <= FIX_W'(cfgPeriod >> 1);
      cntQ    <= '0;
      shregQ  <= '0;
      lastQ   <= cfgQ[CNTF_W-1:0];
    end else begin
      cntQ <= cntQ + 1'b1;
      if (strobe.nextSlot) targetQ <= targetQ + FIX_W'(periodQ);
      if (strobe.shiftBit) shregQ  <= {rxBit, shregQ[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord     <= '0;
      rxReady    <= 1'b0;
      rxOverrun  <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      if (rdStrobe) begin
        rxReady    <= 1'b0;
        rxOverrun  <= 1'b0;
        rxFrameErr <= 1'b0;
      end
      if (strobe.deliver) begin
        rxWord     <= shregQ;
        rxReady    <= 1'b1;
        rxFrameErr <= ~rxBit;
        if (rxReady && !rdStrobe) rxOverrun <= 1'b1;
      end
    end
  end

  // R6: delivery raises ready; a lone read drops it
  p_deliver_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deliver |=> rxReady);
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && rdStrobe && !strobe.deliver) |=> !rxReady);
  // R7: overrun holds until a read
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !rdStrobe) |=> rxOverrun);
  // R8: read and delivery on one edge
  p_collide_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && rdStrobe && strobe.deliver) |=> (rxReady && !rxOverrun));
  // R9: framing flag follows the stop sample
  p_ferr_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deliver |=> (rxFrameErr == !$past(rxBit)));
  // R4: the sample target always advances by at least one clock
  p_target_ahead_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextSlot |=> (targetQ[FIX_W-1:FRAC_W] > $past(cntQ)));
endmodule

// File: rtl/serial_rx_poll.sv
module serial_rx_poll
  import serial_rx_pkg::*;
#(
  parameter int          CNT_W       = 24,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] RESET_CFG   = 32'h0010_0007
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWord,
  input  logic        rdStrobe,
  input  logic        rxIn,
  output logic [31:0] rxWord,
  output logic        rxReady,
  output logic        rxOverrun,
  output logic        rxFrameErr
);
  localparam int WORD_W = 32;
  localparam int CNTF_W = $clog2(WORD_W);

  rxStrobe_t         strobe;
  logic              fallSeen, sampleHit, rxBit;
  logic [CNTF_W-1:0] lastIdx;

  serial_rx_ctrl #(.CNTF_W(CNTF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fallSeen(fallSeen), .sampleHit(sampleHit),
    .rxBit(rxBit), .lastIdx(lastIdx), .strobe(strobe)
  );

  serial_rx_dp #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .RESET_CFG(RESET_CFG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWord(cfgWord),
    .rdStrobe(rdStrobe), .rxIn(rxIn), .strobe(strobe),
    .fallSeen(fallSeen), .sampleHit(sampleHit), .rxBit(rxBit), .lastIdx(lastIdx),
    .rxWord(rxWord), .rxReady(rxReady), .rxOverrun(rxOverrun), .rxFrameErr(rxFrameErr)
  );
endmodule

// File: tb/tb_serial_rx_poll.sv
`timescale 1ns/1ps
module tb_serial_rx_poll;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        rdStrobe = 1'b0;
  logic        rxIn = 1'b1;
  logic [31:0] rxWord;
  logic        rxReady, rxOverrun, rxFrameErr;

  serial_rx_poll dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWord(cfgWord),
    .rdStrobe(rdStrobe), .rxIn(rxIn), .rxWord(rxWord), .rxReady(rxReady),
    .rxOverrun(rxOverrun), .rxFrameErr(rxFrameErr)
  );

  always #2.5 clk = ~clk;

  int     errors = 0;
  int     checks = 0;
  bit     done = 0;
  string  curReq = "R1";
  longint cyc = 0;
  longint pendEdge = -1;
  logic [31:0] pendData;
  logic   pendFerr;
  longint curPfix = 64'h0010_0000;

  // reference model state
  logic [31:0] mData = '0;
  logic mReady = 0, mOvr = 0, mFerr = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      mData = '0; mReady = 0; mOvr = 0; mFerr = 0;
    end else begin
      logic oldReady;
      oldReady = mReady;
      if (rdStrobe) begin mReady = 0; mOvr = 0; mFerr = 0; end
      if (cyc == pendEdge) begin
        mData = pendData; mFerr = pendFerr;
        if (oldReady && !rdStrobe) mOvr = 1;
        mReady = 1;
        pendEdge = -1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rxReady !== mReady || rxOverrun !== mOvr || rxFrameErr !== mFerr || rxWord !== mData) begin
        errors++;
        $display("FAIL %s cycle %0d: rdy/ovr/ferr/word=%b%b%b/%h expected %b%b%b/%h",
                 curReq, cyc, rxReady, rxOverrun, rxFrameErr, rxWord, mReady, mOvr, mFerr, mData);
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk); cfgWrEn = 1; cfgWord = v;
    @(negedge clk); cfgWrEn = 0;
    curPfix = longint'({v[31:5], 5'b0});
  endtask

  task automatic readWord();
    @(negedge clk); rdStrobe = 1;
    @(negedge clk); rdStrobe = 0;
  endtask

  task automatic sendFrame(input logic [31:0] d, input int n, input bit stopBit);
    longint e0, total, seg;
    longint mask;
    @(negedge clk);
    e0 = cyc + 1;
    mask = (64'd1 << n) - 1;
    pendData = 32'((longint'(d) & mask) << (32 - n));
    pendFerr = !stopBit;
    pendEdge = e0 + 3 + ((curPfix >> 1) + (n + 1) * curPfix) / 65536;
    total = ((n + 2) * curPfix) / 65536;
    for (longint j = 0; j < total; j++) begin
      seg = (j * 65536) / curPfix;
      if (seg == 0) rxIn = 0;
      else if (seg <= n) rxIn = d[seg-1];
      else rxIn = stopBit;
      @(negedge clk);
    end
    rxIn = 1;
    while (pendEdge != -1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 ready", rxReady, 0);
    check("R1 overrun", rxOverrun, 0);
    check("R1 frameErr", rxFrameErr, 0);
    check("R1 word", rxWord, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    curReq = "R2";  // default config: 16 clocks, 8 bits
    sendFrame(32'h5A, 8, 1);
    check("R2 default word", rxWord, 32'h5A00_0000);
    readWord();

    curReq = "R5";
    writeCfg(32'h0014_0007);
    sendFrame(32'hA5, 8, 1);
    check("R5 left-justified", rxWord, 32'hA500_0000);
    readWord();

    curReq = "R4";  // 23.5 clocks per bit, back to back
    writeCfg(32'h0017_8007);
    for (int i = 0; i < 3; i++) begin
      sendFrame(32'h31 + i * 32'h22, 8, 1);
      check("R4 fractional word", rxWord, (32'h31 + i * 32'h22) << 24);
      readWord();
    end

    curReq = "R10";
    writeCfg(32'h0013_4004);
    sendFrame(32'h13, 5, 1);
    check("R10 five bits", rxWord, 32'h13 << 27);
    readWord();
    writeCfg(32'h0010_001F);
    sendFrame(32'hDEADBEEF, 32, 1);
    check("R10 thirty-two bits", rxWord, 32'hDEADBEEF);
    readWord();

    curReq = "R3";
    writeCfg(32'h0028_0007);
    @(negedge clk); rxIn = 0;
    repeat (3) @(negedge clk);
    rxIn = 1;
    repeat (120) @(negedge clk);
    check("R3 glitch ignored", rxReady, 0);
    sendFrame(32'h7E, 8, 1);
    check("R3 frame after glitch", rxWord, 32'h7E00_0000);

    curReq = "R6";
    repeat (50) @(negedge clk);
    check("R6 ready held", rxReady, 1);
    readWord();
    check("R6 read clears", rxReady, 0);

    curReq = "R7";
    writeCfg(32'h0012_0007);
    sendFrame(32'h11, 8, 1);
    sendFrame(32'h22, 8, 1);
    check("R7 overwrite", rxWord, 32'h2200_0000);
    check("R7 overrun set", rxOverrun, 1);
    repeat (10) @(negedge clk);
    check("R7 overrun sticky", rxOverrun, 1);
    readWord();
    check("R7 read clears", rxOverrun, 0);

    curReq = "R8";
    sendFrame(32'h44, 8, 1);
    fork
      sendFrame(32'h99, 8, 1);
      begin
        @(negedge clk); @(negedge clk);
        while (cyc != pendEdge - 1) @(negedge clk);
        rdStrobe = 1;
        @(negedge clk); rdStrobe = 0;
      end
    join
    check("R8 ready kept", rxReady, 1);
    check("R8 no overrun", rxOverrun, 0);
    check("R8 new word", rxWord, 32'h9900_0000);
    readWord();

    curReq = "R9";
    sendFrame(32'h3C, 8, 0);
    check("R9 frame error", rxFrameErr, 1);
    check("R9 char delivered", rxWord, 32'h3C00_0000);
    sendFrame(32'hC3, 8, 1);
    check("R9 clean stop clears", rxFrameErr, 0);
    readWord();

    repeat (5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule